// File: doc/BRIEF.md
# Multi-mode floating-point rounding stage

This block is the last step of a binary32 arithmetic unit. An upstream datapath hands it a sign, an unbiased exponent carried with two spare bits, a 24-bit mantissa that includes the hidden bit, the three bits shifted out below the mantissa (guard, round, sticky) and a 3-bit rounding-mode code. The stage decides whether the mantissa is bumped by one unit in the last place, absorbs a carry out of the mantissa into the exponent, resolves results that fall outside the finite range, picks the sign of an exact zero, and emits the packed 32-bit word together with a 5-bit exception vector.

Seven rounding modes are honoured, and each mode has its own policy for results that overflow or underflow, depending on the sign. Two of the modes round to odd and differ only in the sign they give to an exact zero whose sign is otherwise undetermined. The output can be registered (the default, one cycle of latency) or left combinational through a parameter.

Top module: `fpr_round_stage`

## Requirements
- R1: While `rst_n` is low both outputs are zero; with `OUT_REG=1` the packed result and flags for inputs presented before a rising edge appear right after that edge.
- R2: Mode codes are 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf, 4 nearest-away, 5 odd with positive zero, 6 odd with negative zero; code 7 behaves as code 0. In nearest-even the mantissa is incremented when guard is set and any of round, sticky or mantissa bit 0 is set.
- R3: In nearest-away the mantissa is incremented exactly when guard is set.
- R4: Toward zero never increments the mantissa and never yields an all-ones exponent field.
- R5: Toward +inf increments when the sign is 0 and any of guard/round/sticky is set; toward -inf increments when the sign is 1 and any of them is set.
- R6: In both odd modes the mantissa is incremented only when bit 0 is 0 and any of guard/round/sticky is set, so any inexact result has fraction bit 0 equal to 1.
- R7: A carry out of the 24-bit mantissa shifts it right by one and adds one to the exponent before the range test.
- R8: A rounded exponent above 127 sets flag bit 2 and bit 0; the result is infinity for modes 0, 4, 7, for mode 2 when positive and for mode 3 when negative, otherwise the largest finite value (exponent field 0xFE, fraction all ones) of the input sign.
- R9: A rounded exponent below -126 sets flag bit 1 and bit 0; the result is a signed zero for modes 0, 1, 4, 7, for mode 2 when negative and for mode 3 when positive, otherwise the smallest denormal (fraction 1) of the input sign.
- R10: At exponent -126 a mantissa with bit 23 clear packs with exponent field 0 (denormal); such a result with any of guard/round/sticky set also sets flag bit 1; rounding that sets bit 23 packs with exponent field 1.
- R11: When the rounded mantissa is zero the result is zero; if `in_zero_free` is set its sign is 1 for modes 3 and 6 and 0 otherwise, else it is `in_sign`.
- R12: Flag layout is invalid bit 4, divide-by-zero bit 3, overflow bit 2, underflow bit 1, inexact bit 0; bits 4 and 3 are always 0 here and bit 0 is set whenever any of guard/round/sticky is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sign | input | 1 | Sign of the unrounded value, 1 is negative |
| in_exp | input | XEXP_W (10) | Signed unbiased exponent |
| in_mant | input | FRAC_W+1 (24) | Mantissa with hidden bit at the top |
| in_guard | input | 1 | First bit below the mantissa |
| in_round | input | 1 | Second bit below the mantissa |
| in_sticky | input | 1 | OR of all lower discarded bits |
| in_mode | input | 3 | Rounding-mode code |
| in_zero_free | input | 1 | Sign of an exact zero is not fixed by the operation |
| out_result | output | EXP_W+FRAC_W+1 (32) | Packed rounded result |
| out_flags | output | 5 | Exception flags |

## Verification
The bench aims at ties in the two nearest modes with even and odd last bits, where a design that ignored the last bit or the mode would land one unit off. It drives an all-ones mantissa that carries into the exponent, including a carry that pushes the exponent out of range, which a stage that tested range before the carry would pack as a wrong finite number. It walks every directed mode through both signs at overflow and deep underflow, where swapping the per-sign policy gives infinity instead of the largest finite value or zero instead of the smallest denormal. It also covers the denormal boundary and the undetermined-zero sign in the odd and downward modes, which a design keyed only on the input sign would get backwards.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

   typedef enum logic [2:0] {
      RM_NEAR_EVEN = 3'd0,
      RM_TO_ZERO   = 3'd1,
      RM_UPWARD    = 3'd2,
      RM_DOWNWARD  = 3'd3,
      RM_NEAR_AWAY = 3'd4,
      RM_ODD_POSZ  = 3'd5,
      RM_ODD_NEGZ  = 3'd6,
      RM_RESERVED  = 3'd7
   } rmode_e;

   localparam int unsigned FLAG_W      = 5;
   localparam int unsigned FL_INVALID  = 4;
   localparam int unsigned FL_DIVZERO  = 3;
   localparam int unsigned FL_OVF      = 2;
   localparam int unsigned FL_UNF      = 1;
   localparam int unsigned FL_INEXACT  = 0;

   typedef struct packed {
      logic bump;       // increment the mantissa
      logic ovf_inf;    // overflow goes to infinity, else largest finite
      logic unf_zero;   // deep underflow goes to zero, else smallest denormal
      logic zero_neg;   // sign of an undetermined exact zero
   } rpolicy_t;

endpackage

// File: rtl/fpr_mode_policy.sv
module fpr_mode_policy
   import fpr_pkg::*;
(
   input  logic [2:0] mode,
   input  logic       sign,
   input  logic       lsb,
   input  logic       guard,
   input  logic       rnd,
   input  logic       sticky,
   output rpolicy_t   policy
);

   logic   lost;
   rmode_e mode_e;

   assign lost   = guard | rnd | sticky;
   assign mode_e = rmode_e'(mode);

   always_comb begin
      policy = '0;
      case (mode_e)
         RM_TO_ZERO: begin
            policy.bump     = 1'b0;
            policy.ovf_inf  = 1'b0;
            policy.unf_zero = 1'b1;
            policy.zero_neg = 1'b0;
         end
         RM_UPWARD: begin
            policy.bump     = ~sign & lost;
            policy.ovf_inf  = ~sign;
            policy.unf_zero = sign;
            policy.zero_neg = 1'b0;
         end
         RM_DOWNWARD: begin
            policy.bump     = sign & lost;
            policy.ovf_inf  = sign;
            policy.unf_zero = ~sign;
            policy.zero_neg = 1'b1;
         end
         RM_NEAR_AWAY: begin
            policy.bump     = guard;
            policy.ovf_inf  = 1'b1;
            policy.unf_zero = 1'b1;
            policy.zero_neg = 1'b0;
         end
         RM_ODD_POSZ, RM_ODD_NEGZ: begin
            policy.bump     = ~lsb & lost;
            policy.ovf_inf  = 1'b0;
            policy.unf_zero = 1'b0;
            policy.zero_neg = (mode_e == RM_ODD_NEGZ);
         end
         default: begin
            // nearest-even, and the reserved code folded onto it
            policy.bump     = guard & (rnd | sticky | lsb);
            policy.ovf_inf  = 1'b1;
            policy.unf_zero = 1'b1;
            policy.zero_neg = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/fpr_mant_incr.sv
module fpr_mant_incr #(
   parameter int unsigned MANT_W = 24,
   parameter int unsigned XEXP_W = 10
) (
   input  logic                     bump,
   input  logic [MANT_W-1:0]        mant,
   input  logic signed [XEXP_W-1:0] exp_in,
   output logic [MANT_W-1:0]        mant_r,
   output logic signed [XEXP_W:0]   exp_r
);

   localparam int unsigned SUM_W = MANT_W + 1;

   logic [SUM_W-1:0] sum;
   logic             carry;

   assign sum   = {1'b0, mant} + SUM_W'(bump);
   assign carry = sum[SUM_W-1];

   // on carry the value is exactly 2^MANT_W, so dropping the low bit is lossless
   assign mant_r = carry ? sum[SUM_W-1:1] : sum[MANT_W-1:0];
   assign exp_r  = (XEXP_W+1)'(exp_in) + (XEXP_W+1)'(carry);

endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
   import fpr_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   parameter int unsigned XEXP_W = 10
) (
   input  logic                      sign,
   input  logic                      zero_free,
   input  logic                      lost,
   input  rpolicy_t                  policy,
   input  logic [FRAC_W:0]           mant_r,
   input  logic signed [XEXP_W:0]    exp_r,
   output logic [EXP_W+FRAC_W:0]     result,
   output logic [FLAG_W-1:0]         flags
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int EMAX = BIAS;
   localparam int EMIN = 1 - BIAS;

   logic             too_big;
   logic             too_small;
   logic             is_zero;
   logic             zsign;
   logic [EXP_W-1:0] field;

   assign too_big   = exp_r > (XEXP_W+1)'(EMAX);
   assign too_small = exp_r < (XEXP_W+1)'(EMIN);
   assign is_zero   = (mant_r == '0);
   assign zsign     = zero_free ? policy.zero_neg : sign;
   assign field     = mant_r[FRAC_W] ? (exp_r[EXP_W-1:0] + EXP_W'(BIAS)) : '0;

   always_comb begin
      result = '0;
      flags  = '0;
      if (is_zero) begin
         result                 = {zsign, {(EXP_W+FRAC_W){1'b0}}};
         flags[FL_INEXACT]      = lost;
         flags[FL_UNF]          = lost;
      end else if (too_big) begin
         if (policy.ovf_inf)
            result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         else
            result = {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
         flags[FL_OVF]     = 1'b1;
         flags[FL_INEXACT] = 1'b1;
      end else if (too_small) begin
         if (policy.unf_zero)
            result = {sign, {(EXP_W+FRAC_W){1'b0}}};
         else
            result = {sign, {(EXP_W+FRAC_W-1){1'b0}}, 1'b1};
         flags[FL_UNF]     = 1'b1;
         flags[FL_INEXACT] = 1'b1;
      end else begin
         result            = {sign, field, mant_r[FRAC_W-1:0]};
         flags[FL_INEXACT] = lost;
         flags[FL_UNF]     = lost & (field == '0);
      end
   end

endmodule

// File: rtl/fpr_round_stage.sv
module fpr_round_stage
   import fpr_pkg::*;
#(
   parameter int unsigned EXP_W   = 8,
   parameter int unsigned FRAC_W  = 23,
   parameter int unsigned XEXP_W  = EXP_W + 2,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_sign,
   input  logic signed [XEXP_W-1:0] in_exp,
   input  logic [FRAC_W:0]          in_mant,
   input  logic                     in_guard,
   input  logic                     in_round,
   input  logic                     in_sticky,
   input  logic [2:0]               in_mode,
   input  logic                     in_zero_free,
   output logic [EXP_W+FRAC_W:0]    out_result,
   output logic [FLAG_W-1:0]        out_flags
);

   localparam int unsigned MANT_W = FRAC_W + 1;
   localparam int unsigned WORD_W = EXP_W + FRAC_W + 1;

   generate
      if (EXP_W < 3)            begin : g_bad_exp  $error("EXP_W must be at least 3"); end
      if (FRAC_W < 2)           begin : g_bad_frac $error("FRAC_W must be at least 2"); end
      if (XEXP_W < EXP_W + 2)   begin : g_bad_xexp $error("XEXP_W needs two bits beyond EXP_W"); end
   endgenerate

   rpolicy_t                  policy;
   logic [MANT_W-1:0]         mant_r;
   logic signed [XEXP_W:0]    exp_r;
   logic [WORD_W-1:0]         res_c;
   logic [FLAG_W-1:0]         flg_c;
   logic                      lost;

   assign lost = in_guard | in_round | in_sticky;

   fpr_mode_policy u_policy (
      .mode   (in_mode),
      .sign   (in_sign),
      .lsb    (in_mant[0]),
      .guard  (in_guard),
      .rnd    (in_round),
      .sticky (in_sticky),
      .policy (policy)
   );

   fpr_mant_incr #(
      .MANT_W (MANT_W),
      .XEXP_W (XEXP_W)
   ) u_incr (
      .bump   (policy.bump),
      .mant   (in_mant),
      .exp_in (in_exp),
      .mant_r (mant_r),
      .exp_r  (exp_r)
   );

   fpr_pack #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W),
      .XEXP_W (XEXP_W)
   ) u_pack (
      .sign      (in_sign),
      .zero_free (in_zero_free),
      .lost      (lost),
      .policy    (policy),
      .mant_r    (mant_r),
      .exp_r     (exp_r),
      .result    (res_c),
      .flags     (flg_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_result <= '0;
               out_flags  <= '0;
            end else begin
               out_result <= res_c;
               out_flags  <= flg_c;
            end
         end

         AST_TRUNC_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
            (in_mode == RM_TO_ZERO) |=> (out_result[WORD_W-2:FRAC_W] != '1)); // R4

         AST_ODD_LSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
            ((in_mode == RM_ODD_POSZ || in_mode == RM_ODD_NEGZ) && lost) |=> out_result[0]); // R6

         AST_OVF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            out_flags[FL_OVF] |-> (out_flags[FL_INEXACT] && out_result[WORD_W-2:FRAC_W+1] == '1)); // R8

         AST_UNF_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
            out_flags[FL_UNF] |-> (out_result[WORD_W-2:FRAC_W] == '0)); // R9

         AST_LOST_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
            lost |=> out_flags[FL_INEXACT]); // R12
      end else begin : g_comb
         assign out_result = res_c;
         assign out_flags  = flg_c;
      end
   endgenerate

endmodule

// File: tb/test_fpr_round_stage.sv
module test_fpr_round_stage;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_sign = 1'b0;
   logic signed [9:0] in_exp = '0;
   logic [23:0] in_mant = '0;
   logic        in_guard = 1'b0;
   logic        in_round = 1'b0;
   logic        in_sticky = 1'b0;
   logic [2:0]  in_mode = '0;
   logic        in_zero_free = 1'b0;
   logic [31:0] out_result;
   logic [4:0]  out_flags;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpr_round_stage i_fpr_round_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_sign      (in_sign),
      .in_exp       (in_exp),
      .in_mant      (in_mant),
      .in_guard     (in_guard),
      .in_round     (in_round),
      .in_sticky    (in_sticky),
      .in_mode      (in_mode),
      .in_zero_free (in_zero_free),
      .out_result   (out_result),
      .out_flags    (out_flags)
   );

   // {req 4, sign 1, exp 10, mant 24, grs 3, mode 3, zfree 1, result 32, flags 5}
   localparam logic [82:0] VECS [NVEC] = '{
      {4'd2,  1'b0, 10'h000, 24'h800000, 3'b000, 3'd0, 1'b0, 32'h3F800000, 5'h00}, // R2 exact
      {4'd2,  1'b0, 10'h000, 24'h800000, 3'b100, 3'd0, 1'b0, 32'h3F800000, 5'h01}, // R2 tie even
      {4'd2,  1'b0, 10'h000, 24'h800001, 3'b100, 3'd0, 1'b0, 32'h3F800002, 5'h01}, // R2 tie odd
      {4'd2,  1'b0, 10'h000, 24'h800000, 3'b101, 3'd0, 1'b0, 32'h3F800001, 5'h01}, // R2 above half
      {4'd2,  1'b0, 10'h000, 24'h800001, 3'b100, 3'd7, 1'b0, 32'h3F800002, 5'h01}, // R2 reserved code
      {4'd3,  1'b0, 10'h000, 24'h800000, 3'b100, 3'd4, 1'b0, 32'h3F800001, 5'h01}, // R3 tie away
      {4'd3,  1'b0, 10'h000, 24'h800000, 3'b011, 3'd4, 1'b0, 32'h3F800000, 5'h01}, // R3 below half
      {4'd4,  1'b0, 10'h000, 24'h800001, 3'b111, 3'd1, 1'b0, 32'h3F800001, 5'h01}, // R4 truncate
      {4'd5,  1'b0, 10'h000, 24'h800000, 3'b001, 3'd2, 1'b0, 32'h3F800001, 5'h01}, // R5 up pos
      {4'd5,  1'b1, 10'h000, 24'h800000, 3'b001, 3'd2, 1'b0, 32'hBF800000, 5'h01}, // R5 up neg
      {4'd5,  1'b1, 10'h000, 24'h800000, 3'b001, 3'd3, 1'b0, 32'hBF800001, 5'h01}, // R5 down neg
      {4'd5,  1'b0, 10'h000, 24'h800000, 3'b001, 3'd3, 1'b0, 32'h3F800000, 5'h01}, // R5 down pos
      {4'd6,  1'b0, 10'h000, 24'h800000, 3'b010, 3'd5, 1'b0, 32'h3F800001, 5'h01}, // R6 odd even lsb
      {4'd6,  1'b0, 10'h000, 24'h800001, 3'b100, 3'd6, 1'b0, 32'h3F800001, 5'h01}, // R6 odd lsb kept
      {4'd7,  1'b0, 10'h000, 24'hFFFFFF, 3'b100, 3'd0, 1'b0, 32'h40000000, 5'h01}, // R7 carry
      {4'd7,  1'b0, 10'h07F, 24'hFFFFFF, 3'b110, 3'd0, 1'b0, 32'h7F800000, 5'h05}, // R7 carry to overflow
      {4'd8,  1'b0, 10'h080, 24'h800000, 3'b000, 3'd1, 1'b0, 32'h7F7FFFFF, 5'h05}, // R8 trunc sat
      {4'd8,  1'b1, 10'h0C8, 24'h800000, 3'b000, 3'd2, 1'b0, 32'hFF7FFFFF, 5'h05}, // R8 up neg sat
      {4'd8,  1'b1, 10'h0C8, 24'h800000, 3'b000, 3'd3, 1'b0, 32'hFF800000, 5'h05}, // R8 down neg inf
      {4'd8,  1'b0, 10'h0C8, 24'h800000, 3'b000, 3'd5, 1'b0, 32'h7F7FFFFF, 5'h05}, // R8 odd sat
      {4'd8,  1'b1, 10'h0C8, 24'h800000, 3'b000, 3'd4, 1'b0, 32'hFF800000, 5'h05}, // R8 away inf
      {4'd9,  1'b0, 10'h36A, 24'h800000, 3'b000, 3'd0, 1'b0, 32'h00000000, 5'h03}, // R9 even zero
      {4'd9,  1'b0, 10'h36A, 24'h800000, 3'b000, 3'd2, 1'b0, 32'h00000001, 5'h03}, // R9 up pos denorm
      {4'd9,  1'b1, 10'h36A, 24'h800000, 3'b000, 3'd2, 1'b0, 32'h80000000, 5'h03}, // R9 up neg zero
      {4'd9,  1'b1, 10'h36A, 24'h800000, 3'b000, 3'd3, 1'b0, 32'h80000001, 5'h03}, // R9 down neg denorm
      {4'd9,  1'b0, 10'h36A, 24'h800000, 3'b000, 3'd6, 1'b0, 32'h00000001, 5'h03}, // R9 odd denorm
      {4'd10, 1'b0, 10'h382, 24'h400000, 3'b000, 3'd0, 1'b0, 32'h00400000, 5'h00}, // R10 exact denormal
      {4'd10, 1'b0, 10'h382, 24'h400000, 3'b001, 3'd2, 1'b0, 32'h00400001, 5'h03}, // R10 tiny inexact
      {4'd10, 1'b0, 10'h382, 24'h7FFFFF, 3'b100, 3'd0, 1'b0, 32'h00800000, 5'h01}, // R10 promote
      {4'd11, 1'b1, 10'h000, 24'h000000, 3'b000, 3'd0, 1'b1, 32'h00000000, 5'h00}, // R11 even pos zero
      {4'd11, 1'b0, 10'h000, 24'h000000, 3'b000, 3'd3, 1'b1, 32'h80000000, 5'h00}, // R11 down neg zero
      {4'd11, 1'b0, 10'h000, 24'h000000, 3'b000, 3'd6, 1'b1, 32'h80000000, 5'h00}, // R11 odd neg zero
      {4'd11, 1'b1, 10'h000, 24'h000000, 3'b000, 3'd5, 1'b1, 32'h00000000, 5'h00}, // R11 odd pos zero
      {4'd11, 1'b1, 10'h000, 24'h000000, 3'b000, 3'd0, 1'b0, 32'h80000000, 5'h00}  // R11 fixed sign
   };

   task automatic check(input string req, input string what,
                        input logic [36:0] actual, input logic [36:0] expected);
      n_checks++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
      end
   endtask

   task automatic drive(input logic [82:0] v);
      in_sign      = v[78];
      in_exp       = v[77:68];
      in_mant      = v[67:44];
      {in_guard, in_round, in_sticky} = v[43:41];
      in_mode      = v[40:38];
      in_zero_free = v[37];
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: outputs held at zero during reset even with live inputs
      drive(VECS[0]);
      repeat (3) @(negedge clk);
      check("R1", "reset", {out_result, out_flags}, 37'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "first result after release", {out_result, out_flags}, {32'h3F800000, 5'h00});

      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         check($sformatf("R%0d", VECS[i][82:79]), $sformatf("vector %0d", i),
               {out_result, out_flags}, VECS[i][36:0]);
      end

      // R1: asynchronous clear mid-run
      drive(VECS[15]);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", "async clear", {out_result, out_flags}, 37'h0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(VECS[18]);
      @(negedge clk);
      check("R8", "after reset", {out_result, out_flags}, VECS[18][36:0]);

      // R12: flag bits 4 and 3 stay clear on an overflowing, inexact input
      drive({4'd12, 1'b1, 10'h1FF, 24'hFFFFFF, 3'b111, 3'd4, 1'b0, 32'hFF800000, 5'h05});
      @(negedge clk);
      check("R12", "high flags", {32'h0, out_flags}, {32'h0, 5'h05});
      check("R12", "saturated word", {5'h0, out_result}, {5'h0, 32'hFF800000});

      finish_run();
   end

endmodule